// File: doc/BRIEF.md
# Transmit CRC Command and Append Controller

This block sits beside the character path of a synchronous serial transmitter. It holds a small command register written over a parallel bus. It keeps a running 16-bit CRC over every character handed to the serialiser. When the transmitter runs dry at the end of a message, it supplies the check characters itself. Each write carries a two-bit reset code in its top bits. The code can do nothing, pulse a reset to the receive CRC checker, load the transmit CRC with its starting value, or clear the end-of-message latch.

The end-of-message latch decides what happens on an underrun. While the latch is clear, an underrun makes the block emit the two CRC bytes, high byte first, and then set the latch. While the latch is set, an underrun only asks the serialiser for idle fill. Software clears the latch before each message, and the clear is accepted only while the transmitter is enabled.

In bit-oriented (SDLC) framing the CRC starts from all ones, uses the CCITT polynomial and is sent inverted. In the other synchronous modes it starts from zero, uses the CRC-16 polynomial and is sent as it is.

Top module: `txcrc_ctl`

## Requirements
- R1: After a hardware reset (rst_n low), rd_data, cmd_field, loop_mode, crc_value, app_valid, fill_req and rx_crc_rst are all zero, and eom_latch is one.
- R2: A write stores wr_data[5:3] in cmd_field and wr_data[0] in loop_mode, visible the cycle after the write. rd_data always reads {7'b0, loop_mode}. Bits 2:1 and reset code 00 change nothing.
- R3: rx_crc_rst is high for the cycle after any cycle in which a write carries reset code 01, rx_enable is low, or enter_hunt is high. Otherwise it is low.
- R4: A write with reset code 10 loads crc_value with 16'hFFFF when sdlc_mode is 1 and with 16'h0000 when it is 0, visible the next cycle. This load wins over a character accepted in the same cycle.
- R5: Each cycle with tx_char_valid high, outside an append, advances crc_value by the 8 bits of tx_char, most significant bit first. Each bit does crc = (crc<<1) ^ (poly if crc[15] xor bit), with poly 16'h1021 in SDLC mode and 16'h8005 otherwise. The new value is visible the next cycle.
- R6: A write with reset code 11 clears eom_latch the next cycle when tx_enable is high. With tx_enable low the latch keeps its value.
- R7: An underrun with eom_latch clear and no append in progress drives app_valid high for the next two cycles. The first of these carries crc_value[15:8] and the second carries crc_value[7:0] with app_last high. Both bytes are one's complemented in SDLC mode. eom_latch reads one in the cycle after app_last.
- R8: An underrun with eom_latch set produces a one-cycle fill_req pulse the next cycle and no app_valid.
- R9: While app_valid is high, tx_char_valid and tx_underrun are ignored: crc_value holds, and no fill_req or further append follows.
- R10: A one-cycle chan_rst puts the block in the same state as R1, visible the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| chan_rst | input | 1 | Synchronous channel reset |
| wr_en | input | 1 | Command register write strobe |
| wr_data | input | 8 | Write data: reset code [7:6], command [5:3], loop [0] |
| rd_data | output | 8 | Read value of the command register |
| sdlc_mode | input | 1 | 1 = bit-oriented framing, 0 = other synchronous modes |
| tx_enable | input | 1 | Transmitter enabled |
| rx_enable | input | 1 | Receiver enabled |
| enter_hunt | input | 1 | Receiver enter-hunt request |
| tx_char_valid | input | 1 | A character is being transmitted this cycle |
| tx_char | input | 8 | The character being transmitted |
| tx_underrun | input | 1 | The transmitter has no data to send |
| cmd_field | output | 3 | Stored command field |
| loop_mode | output | 1 | Stored loop-mode bit |
| rx_crc_rst | output | 1 | Reset strobe for the receive CRC checker |
| crc_value | output | 16 | Current transmit CRC |
| app_valid | output | 1 | A CRC byte is being supplied |
| app_byte | output | 8 | CRC byte supplied to the serialiser |
| app_last | output | 1 | Second and last CRC byte |
| fill_req | output | 1 | Request for idle fill |
| eom_latch | output | 1 | End-of-message latch |

## Verification
A CRC register that is preset wrongly, or stepped with the wrong polynomial or bit order, shows on crc_value one cycle after the offending write or character. The bench compares that output after every character, in both framing modes. A latch or sequencer in the wrong state shows within two cycles of an underrun: as a missing or extra app_valid, a CRC byte in the wrong order or polarity, an unexpected fill_req, or eom_latch not reading one after app_last. A command decode fault shows the cycle after a write, on cmd_field, loop_mode, rx_crc_rst, crc_value or eom_latch.

// File: rtl/txcrc_pkg.sv
package txcrc_pkg;
   typedef enum logic [1:0] {
      RC_NONE  = 2'b00,
      RC_RXCRC = 2'b01,
      RC_TXCRC = 2'b10,
      RC_EOM   = 2'b11
   } rst_code_e;

   typedef enum logic [1:0] {
      AP_IDLE = 2'd0,
      AP_HI   = 2'd1,
      AP_LO   = 2'd2
   } app_state_e;
endpackage

// File: rtl/txcrc_step.sv
module txcrc_step #(
   parameter int DATA_W = 8,
   parameter int CRC_W  = 16,
   parameter logic [CRC_W-1:0] POLY_SDLC = 16'h1021,
   parameter logic [CRC_W-1:0] POLY_SYNC = 16'h8005
) (
   input  logic [CRC_W-1:0]  crc_in,
   input  logic [DATA_W-1:0] data,
   input  logic              sdlc,
   output logic [CRC_W-1:0]  crc_out
);
   logic [CRC_W-1:0] poly;

   assign poly = sdlc ? POLY_SDLC : POLY_SYNC;

   always_comb begin
      logic [CRC_W-1:0] acc;
      logic             fb;
      acc = crc_in;
      for (int b = DATA_W - 1; b >= 0; b--) begin
         fb  = acc[CRC_W-1] ^ data[b];
         acc = {acc[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & poly);
      end
      crc_out = acc;
   end
endmodule

// File: rtl/txcrc_cmd.sv
module txcrc_cmd
   import txcrc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CMD_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_rst,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tx_enable,
   input  logic              rx_enable,
   input  logic              enter_hunt,
   output logic [CMD_W-1:0]  cmd_field,
   output logic              loop_mode,
   output logic              rx_crc_rst,
   output logic              tx_preset,
   output logic              eom_clr
);
   localparam int CODE_LO = DATA_W - 2;
   localparam int CMD_LO  = CODE_LO - CMD_W;

   rst_code_e code;

   assign code      = rst_code_e'(wr_data[DATA_W-1:CODE_LO]);
   assign tx_preset = wr_en && (code == RC_TXCRC);
   assign eom_clr   = wr_en && (code == RC_EOM) && tx_enable;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_field  <= '0;
         loop_mode  <= 1'b0;
         rx_crc_rst <= 1'b0;
      end else if (chan_rst) begin
         cmd_field  <= '0;
         loop_mode  <= 1'b0;
         rx_crc_rst <= 1'b0;
      end else begin
         rx_crc_rst <= (wr_en && (code == RC_RXCRC)) || !rx_enable || enter_hunt;
         if (wr_en) begin
            cmd_field <= wr_data[CODE_LO-1:CMD_LO];
            loop_mode <= wr_data[0];
         end
      end
   end

   // R3
   rx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (code == RC_RXCRC) && !chan_rst) |=> rx_crc_rst);
   // R2
   loop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !chan_rst) |=> (loop_mode == $past(wr_data[0])));
endmodule

// File: rtl/txcrc_append.sv
module txcrc_append
   import txcrc_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int CRC_W    = 16,
   parameter bit INV_SDLC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_rst,
   input  logic              tx_underrun,
   input  logic              eom_clr,
   input  logic              sdlc_mode,
   input  logic [CRC_W-1:0]  crc_value,
   output logic              app_valid,
   output logic [DATA_W-1:0] app_byte,
   output logic              app_last,
   output logic              fill_req,
   output logic              eom_latch
);
   app_state_e        state;
   logic [DATA_W-1:0] raw_byte;
   logic [DATA_W-1:0] inv_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= AP_IDLE;
         eom_latch <= 1'b1;
         fill_req  <= 1'b0;
      end else if (chan_rst) begin
         state     <= AP_IDLE;
         eom_latch <= 1'b1;
         fill_req  <= 1'b0;
      end else begin
         fill_req <= tx_underrun && eom_latch && (state == AP_IDLE);
         unique case (state)
            AP_IDLE: if (tx_underrun && !eom_latch) state <= AP_HI;
            AP_HI:   state <= AP_LO;
            default: state <= AP_IDLE;
         endcase
         if (state == AP_LO)
            eom_latch <= 1'b1;
         else if (eom_clr)
            eom_latch <= 1'b0;
      end
   end

   assign app_valid = (state != AP_IDLE);
   assign app_last  = (state == AP_LO);
   assign raw_byte  = (state == AP_HI) ? crc_value[CRC_W-1:DATA_W]
                                       : crc_value[DATA_W-1:0];

   generate
      if (INV_SDLC) begin : g_inv
         assign inv_mask = {DATA_W{sdlc_mode}};
      end else begin : g_plain
         assign inv_mask = '0;
      end
   endgenerate

   assign app_byte = raw_byte ^ inv_mask;

   // R7
   two_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (app_valid && !app_last && !chan_rst) |=> (app_valid && app_last));
   // R7
   latch_after_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      app_last |=> eom_latch);
   // R8
   latched_no_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eom_latch |=> !app_valid);
   // R9
   no_fill_in_append_chk: assert property (@(posedge clk) disable iff (!rst_n)
      app_valid |=> !fill_req);
endmodule

// File: rtl/txcrc_ctl.sv
module txcrc_ctl
   import txcrc_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int CRC_W    = 16,
   parameter int CMD_W    = 3,
   parameter bit INV_SDLC = 1'b1,
   parameter logic [CRC_W-1:0] POLY_SDLC = 16'h1021,
   parameter logic [CRC_W-1:0] POLY_SYNC = 16'h8005
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_rst,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              sdlc_mode,
   input  logic              tx_enable,
   input  logic              rx_enable,
   input  logic              enter_hunt,
   input  logic              tx_char_valid,
   input  logic [DATA_W-1:0] tx_char,
   input  logic              tx_underrun,
   output logic [CMD_W-1:0]  cmd_field,
   output logic              loop_mode,
   output logic              rx_crc_rst,
   output logic [CRC_W-1:0]  crc_value,
   output logic              app_valid,
   output logic [DATA_W-1:0] app_byte,
   output logic              app_last,
   output logic              fill_req,
   output logic              eom_latch
);
   localparam logic [CRC_W-1:0] SDLC_SEED = '1;
   localparam logic [CRC_W-1:0] SYNC_SEED = '0;

   generate
      if (CRC_W != 2 * DATA_W) begin : g_bad_w
         $error("txcrc_ctl: CRC_W must be twice DATA_W");
      end
      if (DATA_W < CMD_W + 3) begin : g_bad_cmd
         $error("txcrc_ctl: DATA_W too small for the command layout");
      end
   endgenerate

   logic             tx_preset;
   logic             eom_clr;
   logic [CRC_W-1:0] crc_next;

   txcrc_cmd #(.DATA_W(DATA_W), .CMD_W(CMD_W)) cmd_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .chan_rst   (chan_rst),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .tx_enable  (tx_enable),
      .rx_enable  (rx_enable),
      .enter_hunt (enter_hunt),
      .cmd_field  (cmd_field),
      .loop_mode  (loop_mode),
      .rx_crc_rst (rx_crc_rst),
      .tx_preset  (tx_preset),
      .eom_clr    (eom_clr)
   );

   txcrc_step #(.DATA_W(DATA_W), .CRC_W(CRC_W),
                .POLY_SDLC(POLY_SDLC), .POLY_SYNC(POLY_SYNC)) step_i (
      .crc_in  (crc_value),
      .data    (tx_char),
      .sdlc    (sdlc_mode),
      .crc_out (crc_next)
   );

   txcrc_append #(.DATA_W(DATA_W), .CRC_W(CRC_W), .INV_SDLC(INV_SDLC)) app_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .chan_rst    (chan_rst),
      .tx_underrun (tx_underrun),
      .eom_clr     (eom_clr),
      .sdlc_mode   (sdlc_mode),
      .crc_value   (crc_value),
      .app_valid   (app_valid),
      .app_byte    (app_byte),
      .app_last    (app_last),
      .fill_req    (fill_req),
      .eom_latch   (eom_latch)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         crc_value <= '0;
      else if (chan_rst)
         crc_value <= '0;
      else if (tx_preset)
         crc_value <= sdlc_mode ? SDLC_SEED : SYNC_SEED;
      else if (tx_char_valid && !app_valid)
         crc_value <= crc_next;
   end

   assign rd_data = {{(DATA_W-1){1'b0}}, loop_mode};

   // R4
   preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_preset && !chan_rst) |=>
         (crc_value == ($past(sdlc_mode) ? SDLC_SEED : SYNC_SEED)));
   // R9
   crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (app_valid && !tx_preset && !chan_rst) |=> $stable(crc_value));
   // R6
   latch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_data[DATA_W-1 -: 2] == RC_EOM) && !tx_enable
       && eom_latch && !chan_rst) |=> eom_latch);
endmodule

// File: tb/txcrc_ctl_tb_top.sv
module txcrc_ctl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chan_rst = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = '0;
   logic [7:0]  rd_data;
   logic        sdlc_mode = 1'b0;
   logic        tx_enable = 1'b0;
   logic        rx_enable = 1'b1;
   logic        enter_hunt = 1'b0;
   logic        tx_char_valid = 1'b0;
   logic [7:0]  tx_char = '0;
   logic        tx_underrun = 1'b0;
   logic [2:0]  cmd_field;
   logic        loop_mode;
   logic        rx_crc_rst;
   logic [15:0] crc_value;
   logic        app_valid;
   logic [7:0]  app_byte;
   logic        app_last;
   logic        fill_req;
   logic        eom_latch;

   int vectors = 0;
   int errors  = 0;
   logic [15:0] model;

   always #4 clk = ~clk;

   txcrc_ctl dut_i (
      .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .sdlc_mode(sdlc_mode),
      .tx_enable(tx_enable), .rx_enable(rx_enable), .enter_hunt(enter_hunt),
      .tx_char_valid(tx_char_valid), .tx_char(tx_char),
      .tx_underrun(tx_underrun), .cmd_field(cmd_field), .loop_mode(loop_mode),
      .rx_crc_rst(rx_crc_rst), .crc_value(crc_value), .app_valid(app_valid),
      .app_byte(app_byte), .app_last(app_last), .fill_req(fill_req),
      .eom_latch(eom_latch)
   );

   function automatic logic [15:0] crc_model(logic [15:0] c, logic [7:0] d, logic s);
      logic [15:0] p = s ? 16'h1021 : 16'h8005;
      for (int i = 7; i >= 0; i--) begin
         if (c[15] ^ d[i]) c = (c << 1) ^ p;
         else              c = c << 1;
      end
      return c;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check_reset_state(input string req);
      chk(rd_data == 8'h00, req, rd_data, 0);
      chk(cmd_field == 3'd0, req, cmd_field, 0);
      chk(loop_mode == 1'b0, req, loop_mode, 0);
      chk(crc_value == 16'h0, req, crc_value, 0);
      chk(app_valid == 1'b0, req, app_valid, 0);
      chk(fill_req == 1'b0, req, fill_req, 0);
      chk(rx_crc_rst == 1'b0, req, rx_crc_rst, 0);
      chk(eom_latch == 1'b1, req, eom_latch, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check_reset_state("R1");
      model = 16'h0;

      // R2 R3 R4 R6: sweep every write value with the transmitter disabled
      for (int w = 0; w < 256; w++) begin
         sdlc_mode = w[1];
         wr_en = 1'b1; wr_data = w[7:0];
         cyc();
         wr_en = 1'b0;
         if (w[7:6] == 2'b10) model = w[1] ? 16'hFFFF : 16'h0000;
         chk(cmd_field == w[5:3], "R2", cmd_field, w[5:3]);
         chk(loop_mode == w[0], "R2", loop_mode, w[0]);
         chk(rd_data == {7'b0, w[0]}, "R2", rd_data, {7'b0, w[0]});
         chk(rx_crc_rst == (w[7:6] == 2'b01), "R3", rx_crc_rst, w[7:6] == 2'b01);
         chk(crc_value == model, "R4", crc_value, model);
         chk(eom_latch == 1'b1, "R6 ignored", eom_latch, 1);
      end

      // R5 R6 R7 R8 R9 in both framing modes
      for (int m = 0; m < 2; m++) begin
         sdlc_mode = m[0];
         tx_enable = 1'b1;
         wr_en = 1'b1; wr_data = 8'h80;
         cyc();
         wr_en = 1'b0;
         model = m[0] ? 16'hFFFF : 16'h0000;
         chk(crc_value == model, "R4", crc_value, model);
         for (int i = 0; i < 64; i++) begin
            tx_char_valid = 1'b1; tx_char = 8'((i * 37) + (m * 11));
            cyc();
            model = crc_model(model, tx_char, m[0]);
            chk(crc_value == model, "R5", crc_value, model);
         end
         tx_char_valid = 1'b0;
         // latch still set: underrun asks for fill
         tx_underrun = 1'b1;
         cyc();
         tx_underrun = 1'b0;
         chk(fill_req == 1'b1, "R8", fill_req, 1);
         chk(app_valid == 1'b0, "R8", app_valid, 0);
         cyc();
         chk(fill_req == 1'b0, "R8", fill_req, 0);
         // clear the latch while enabled
         wr_en = 1'b1; wr_data = 8'hC0;
         cyc();
         wr_en = 1'b0;
         chk(eom_latch == 1'b0, "R6", eom_latch, 0);
         tx_underrun = 1'b1;
         cyc();
         chk(app_valid == 1'b1, "R7", app_valid, 1);
         chk(app_last == 1'b0, "R7", app_last, 0);
         chk(app_byte == (model[15:8] ^ {8{m[0]}}), "R7", app_byte, model[15:8] ^ {8{m[0]}});
         // underrun and a character during the append are ignored
         tx_char_valid = 1'b1; tx_char = 8'h5A;
         cyc();
         tx_underrun = 1'b0; tx_char_valid = 1'b0;
         chk(app_valid && app_last, "R7", {app_valid, app_last}, 2'b11);
         chk(app_byte == (model[7:0] ^ {8{m[0]}}), "R7", app_byte, model[7:0] ^ {8{m[0]}});
         chk(crc_value == model, "R9", crc_value, model);
         chk(fill_req == 1'b0, "R9", fill_req, 0);
         cyc();
         chk(eom_latch == 1'b1, "R7", eom_latch, 1);
         chk(app_valid == 1'b0, "R9", app_valid, 0);
         chk(fill_req == 1'b0, "R9", fill_req, 0);
         chk(crc_value == model, "R9", crc_value, model);
      end

      // R4 preset wins over a character in the same cycle
      sdlc_mode = 1'b1;
      wr_en = 1'b1; wr_data = 8'h80; tx_char_valid = 1'b1; tx_char = 8'h3C;
      cyc();
      wr_en = 1'b0; tx_char_valid = 1'b0;
      chk(crc_value == 16'hFFFF, "R4 precedence", crc_value, 16'hFFFF);
      sdlc_mode = 1'b0;
      wr_en = 1'b1; wr_data = 8'h80; tx_char_valid = 1'b1;
      cyc();
      wr_en = 1'b0; tx_char_valid = 1'b0;
      chk(crc_value == 16'h0000, "R4 precedence", crc_value, 0);

      // R3 receiver-side sources
      rx_enable = 1'b0;
      cyc();
      rx_enable = 1'b1;
      chk(rx_crc_rst == 1'b1, "R3", rx_crc_rst, 1);
      enter_hunt = 1'b1;
      cyc();
      enter_hunt = 1'b0;
      chk(rx_crc_rst == 1'b1, "R3", rx_crc_rst, 1);
      cyc();
      chk(rx_crc_rst == 1'b0, "R3", rx_crc_rst, 0);

      // R10 channel reset
      wr_en = 1'b1; wr_data = 8'hEB;
      cyc();
      wr_en = 1'b0;
      tx_char_valid = 1'b1; tx_char = 8'h99;
      cyc();
      tx_char_valid = 1'b0;
      chk(eom_latch == 1'b0, "R6", eom_latch, 0);
      chk(loop_mode == 1'b1, "R2", loop_mode, 1);
      chan_rst = 1'b1;
      cyc();
      chan_rst = 1'b0;
      check_reset_state("R10");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule